// File: doc/BRIEF.md
# Serial Digit Readout with Call-Progress Sharing

This block takes a 4-bit digit code and its valid level from an upstream digit validator and sends the code out on a single serial data pin. An external controller reads the bits by pulsing an acknowledge line. That line is asynchronous to the block. The pin shows one bit at a time, least significant bit first. The block synchronises the acknowledge line into the system clock domain and detects its rising edges there. For this reason the system clock must run at least eight times faster than the fastest acknowledge rate.

When no digit is waiting to be read, the same pin carries a call-progress indicator. This indicator is a filtered copy of a raw supervisory-tone energy flag. It sets only after the energy has been present without a break for an attack window. It clears only after the energy has been absent without a break for a decay window. Both windows are counted in whole milliseconds, which lets the controller follow the tone cadence.

The code input has no back-pressure. The validator holds the code and the valid level steady for as long as the digit is pending. A drop of the valid level withdraws the digit.

Top module: `digit_serial_mux`

## Requirements
- R1: After reset, sd is 0, the readout is idle and the call-progress indicator is clear.
- R2: A rising edge of code_valid loads code. Bit 0 of the loaded code appears on sd after the next clock edge.
- R3: Each rising edge of ack during a readout moves sd to the next bit in the order bit 0, bit 1, bit 2, bit 3. The new bit appears on the third clock edge after ack goes high.
- R4: The fourth ack rising edge ends the readout, and sd returns to the call-progress indicator.
- R5: If code_valid goes low during a readout, the readout ends and sd shows the call-progress indicator from the next clock edge.
- R6: Ack pulses have no effect while no readout is active. A code_valid held high after a finished readout does not start a second readout.
- R7: The call-progress indicator sets exactly ATTACK_MS*CLKS_PER_MS clock edges after cp_energy rises, provided cp_energy stays high that whole time.
- R8: The call-progress indicator clears exactly DECAY_MS*CLKS_PER_MS clock edges after cp_energy falls, provided cp_energy stays low that whole time.
- R9: A burst of energy shorter than the attack window, or a gap shorter than the decay window, leaves the indicator unchanged. The next window is counted again from zero.
- R10: While a readout is active, sd carries the digit bits whatever the state of the call-progress indicator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the acknowledge rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| code | input | 4 | Digit code from the validator |
| code_valid | input | 1 | High while a validated digit is pending |
| ack | input | 1 | External acknowledge clock, asynchronous |
| cp_energy | input | 1 | Raw supervisory-tone energy flag |
| sd | output | 1 | Shared serial data / call-progress output |

## Verification
Each result has a fixed latency after its stimulus:
- A code_valid rise shows on sd after one clock edge.
- An ack rise shows after three edges: two synchroniser flops, then the shift.
- A code_valid drop shows after one edge.
- An indicator change shows after exactly the window length in clock edges.

The bench changes inputs on falling clock edges and samples sd on falling edges. For the table walk it waits four edges after each ack change, which is well past the three-edge latency. The directed tests sample at the edge just before each change and again at the edge where the change is due, so they prove the exact cycle.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;
  typedef enum logic {RD_IDLE = 1'b0, RD_SHIFT = 1'b1} rd_state_t;
endpackage

// File: rtl/dsm_ack_sync.sv
module dsm_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_async,
  output logic ack_rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], ack_async};
  end

  assign ack_rise = chain[STAGES-1] & ~chain[STAGES];

  // R3
  ack_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rise |=> !ack_rise);
endmodule

// File: rtl/dsm_shifter.sv
module dsm_shifter
  import dsm_pkg::*;
#(
  parameter int W = DIGIT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] code,
  input  logic         code_valid,
  input  logic         ack_rise,
  output logic         busy,
  output logic         bit_out
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  rd_state_t     state;
  logic [W-1:0]  sreg;
  logic [CW-1:0] cnt;
  logic          cv_q;
  logic          cv_rise;

  assign cv_rise = code_valid & ~cv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RD_IDLE;
      sreg  <= '0;
      cnt   <= '0;
      cv_q  <= 1'b0;
    end else begin
      cv_q <= code_valid;
      if (!code_valid) begin
        state <= RD_IDLE;
      end else if (cv_rise) begin
        state <= RD_SHIFT;
        sreg  <= code;
        cnt   <= '0;
      end else if (state == RD_SHIFT && ack_rise) begin
        if (cnt == LAST) begin
          state <= RD_IDLE;
        end else begin
          sreg <= sreg >> 1;
          cnt  <= cnt + 1'b1;
        end
      end
    end
  end

  assign busy    = (state == RD_SHIFT);
  assign bit_out = sreg[0];

  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cv_rise |=> (busy && sreg == $past(code)));
  // R4
  end_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(!code_valid) || $past(ack_rise)));
  // R6
  no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cv_rise));
endmodule

// File: rtl/dsm_cp_filter.sv
module dsm_cp_filter #(
  parameter int CLKS_PER_MS = 8000,
  parameter int ATTACK_MS   = 4,
  parameter int DECAY_MS    = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic energy,
  output logic ind
);
  localparam int MAXMS = (ATTACK_MS > DECAY_MS) ? ATTACK_MS : DECAY_MS;
  localparam int PW    = $clog2(CLKS_PER_MS + 1);
  localparam int MW    = $clog2(MAXMS + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(CLKS_PER_MS - 1);
  localparam logic [MW-1:0] ATK_LAST = MW'(ATTACK_MS - 1);
  localparam logic [MW-1:0] DEC_LAST = MW'(DECAY_MS - 1);

  logic [PW-1:0] pre;
  logic [MW-1:0] ms;
  logic [MW-1:0] ms_last;

  assign ms_last = ind ? DEC_LAST : ATK_LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      ms  <= '0;
      ind <= 1'b0;
    end else if (energy == ind) begin
      pre <= '0;
      ms  <= '0;
    end else if (pre == PRE_LAST) begin
      pre <= '0;
      if (ms == ms_last) begin
        ms  <= '0;
        ind <= ~ind;
      end else begin
        ms <= ms + 1'b1;
      end
    end else begin
      pre <= pre + 1'b1;
    end
  end

  // R7
  attack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ind) |-> $past(energy));
  // R8
  decay_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ind) |-> $past(!energy));
endmodule

// File: rtl/digit_serial_mux.sv
module digit_serial_mux
  import dsm_pkg::*;
#(
  parameter int CLKS_PER_MS = 8000,
  parameter int ATTACK_MS   = 4,
  parameter int DECAY_MS    = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   code,
  input  logic         code_valid,
  input  logic         ack,
  input  logic         cp_energy,
  output logic         sd
);
  logic ack_rise;
  logic busy;
  logic bit_out;
  logic cp_ind;

  dsm_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ack_async(ack), .ack_rise(ack_rise));

  dsm_shifter #(.W(DIGIT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .code(code), .code_valid(code_valid),
    .ack_rise(ack_rise), .busy(busy), .bit_out(bit_out));

  dsm_cp_filter #(.CLKS_PER_MS(CLKS_PER_MS), .ATTACK_MS(ATTACK_MS),
                  .DECAY_MS(DECAY_MS)) u_cp (
    .clk(clk), .rst_n(rst_n), .energy(cp_energy), .ind(cp_ind));

  assign sd = busy ? bit_out : cp_ind;

  // R5
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(code_valid) |-> (sd == cp_ind));
endmodule

// File: tb/sim_digit_serial_mux.sv
module sim_digit_serial_mux;
  localparam int CPM = 10;
  localparam int ATK = 4;
  localparam int DEC = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] code = '0;
  logic code_valid = 1'b0;
  logic ack = 1'b0;
  logic cp_energy = 1'b0;
  logic sd;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  digit_serial_mux #(.CLKS_PER_MS(CPM), .ATTACK_MS(ATK), .DECAY_MS(DEC)) u0 (
    .clk(clk), .rst_n(rst_n), .code(code), .code_valid(code_valid),
    .ack(ack), .cp_energy(cp_energy), .sd(sd));

  // {code[3:0], acks before code_valid drop (4 = full readout)}
  localparam logic [6:0] VEC [8] = '{
    {4'b0101, 3'd4}, {4'b1010, 3'd4}, {4'b0000, 3'd4}, {4'b1111, 3'd4},
    {4'b0110, 3'd1}, {4'b1001, 3'd2}, {4'b0011, 3'd0}, {4'b1100, 3'd3}};

  task automatic chk(input logic exp, input string tag);
    tests++;
    if (sd !== exp) begin
      fails++;
      $display("FAIL %s: sd=%b expected %b", tag, sd, exp);
    end
  endtask

  task automatic ack_pulse();
    ack = 1'b1;
    repeat (4) @(negedge clk);
    ack = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic walk(input logic cp);
    for (int v = 0; v < 8; v++) begin
      logic [3:0] c;
      int n;
      c = VEC[v][6:3];
      n = int'(VEC[v][2:0]);
      code = c;
      code_valid = 1'b1;
      @(negedge clk);
      chk(c[0], "R2/R10 bit0");
      for (int a = 0; a < n; a++) begin
        ack_pulse();
        if (a < 3) chk(c[a+1], "R3/R10 next bit");
        else       chk(cp, "R4 return to indicator");
      end
      code_valid = 1'b0;
      @(negedge clk);
      if (n < 4) chk(cp, "R5 abort");
      repeat (2) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(1'b0, "R1 reset");

    walk(1'b0);

    // R7 exact attack timing
    cp_energy = 1'b1;
    repeat (ATK*CPM - 1) @(negedge clk);
    chk(1'b0, "R7 before attack end");
    @(negedge clk);
    chk(1'b1, "R7 attack done");

    walk(1'b1);

    // R3 exact ack latency, with the indicator set
    code = 4'b0101;
    code_valid = 1'b1;
    @(negedge clk);
    chk(1'b1, "R2 bit0");
    ack = 1'b1;
    @(negedge clk);
    chk(1'b1, "R3 edge1");
    @(negedge clk);
    chk(1'b1, "R3 edge2");
    @(negedge clk);
    chk(1'b0, "R3 edge3");
    repeat (3) @(negedge clk);
    ack = 1'b0;
    repeat (4) @(negedge clk);
    for (int a = 0; a < 3; a++) ack_pulse();
    chk(1'b1, "R4 idle after 4");
    // R6: code_valid still high, more acks, no reload
    ack_pulse();
    ack_pulse();
    chk(1'b1, "R6 no reload");
    code_valid = 1'b0;
    repeat (2) @(negedge clk);

    // R8 exact decay timing
    cp_energy = 1'b0;
    repeat (DEC*CPM - 1) @(negedge clk);
    chk(1'b1, "R8 before decay end");
    @(negedge clk);
    chk(1'b0, "R8 decay done");

    // R6 acks while idle, indicator clear
    ack_pulse();
    chk(1'b0, "R6 idle ack");

    // R9 short burst, then a full attack window counted from zero
    cp_energy = 1'b1;
    repeat (ATK*CPM - 5) @(negedge clk);
    cp_energy = 1'b0;
    @(negedge clk);
    cp_energy = 1'b1;
    repeat (ATK*CPM - 1) @(negedge clk);
    chk(1'b0, "R9 burst restart");
    @(negedge clk);
    chk(1'b1, "R9 attack after restart");

    // R9 short gap
    cp_energy = 1'b0;
    repeat (DEC*CPM - 10) @(negedge clk);
    cp_energy = 1'b1;
    repeat (DEC*CPM) @(negedge clk);
    chk(1'b1, "R9 gap ignored");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    tests++;
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule